// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits between a set of interrupt sources and a processor core that has two interrupt inputs: a fast one and a normal one, both active low. Source 0 is the fast line. Sources 1 to 3 are external request lines. Sources 4 and up are on-chip peripheral lines, and their number is set by a parameter. Every source is level sensitive and has its own enable bit. Each normal source also has a 3-bit priority and a programmable handler vector.

The fast line does not pass through any arbitration. Whenever it is high and enabled, it drives the fast output low. The normal sources are arbitrated by priority. The core reads the vector register to get the handler address of the winning source. That read also acknowledges the source: its priority is pushed onto an in-service stack, so from then on only a strictly higher priority can raise the normal output again. When the handler finishes, it writes the end-of-interrupt register. This pops the stack and opens arbitration again to the lower priorities.

Software reaches the block through a simple single-cycle register port. Read data is registered and appears in the cycle after the read.

Top module: `vic_ctrl`

## Requirements
- R1: After reset, every enable bit is 0, every priority, vector, spurious vector and fast vector is 0, the in-service stack is empty, `fiq_no` and `irq_no` are high, and `bus_rdata_o` is 0.
- R2: `fiq_no` is low exactly when `src_i[0]` is high and enable bit 0 is set. The priorities and the in-service stack have no effect on it.
- R3: A write to address 2 sets every enable bit whose data bit is 1. A write to address 3 clears every enable bit whose data bit is 1. Data bits that are 0 leave their enable bits unchanged. A read of address 2 returns the enable bits, with bit k belonging to source k.
- R4: `irq_no` is low exactly when some enabled normal source is high and, in addition, either the stack is empty or that source's priority is strictly greater than the priority on top of the stack.
- R5: A read of address 0 returns the vector of the eligible source that has the highest priority. When priorities are equal, the lowest source number wins. `bus_rdata_o` carries the result in the next cycle. In a cycle after a cycle without a read, `bus_rdata_o` is 0.
- R6: A read of address 0 while no source is eligible returns the spurious vector (address 4) and leaves the in-service stack unchanged.
- R7: A read of address 0 that returns a source's vector pushes that source's priority onto the stack. The stack holds up to 8 entries, which allows nesting across all eight levels.
- R8: Any write to address 1 pops one stack entry. If the stack is already empty, the write has no effect.
- R9: Normal source k (k ≥ 1) takes its priority from bits [2:0] of address 15+k and its vector from address 31+k. The fast vector is at address 5 and the spurious vector is at address 4. Each of these addresses reads back what was written to it. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | N_PERIPH+4 | Level-sensitive sources; bit 0 is the fast line |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 6 | Register word address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data |
| fiq_no | output | 1 | Fast interrupt request to the core, active low |
| irq_no | output | 1 | Normal interrupt request to the core, active low |

## Verification
A vector read can land in the same cycle as a change on the source lines. The arbitration for that read uses the source levels present in that cycle. To provoke this, the bench raises a higher-priority source in exactly the cycle of the read, and it also drops the only pending source in the cycle of a read. The behavioural model has to agree both on the vector returned (the new source in the first case, the spurious vector in the second) and on whether the read pushed the stack. Randomized mixes of reads, end-of-interrupt writes and enable changes on top of toggling sources add many more of these collisions.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int ADDR_W      = 6;
    localparam int A_VEC       = 0;
    localparam int A_EOI       = 1;
    localparam int A_MSET      = 2;
    localparam int A_MCLR      = 3;
    localparam int A_SPUR      = 4;
    localparam int A_FVEC      = 5;
    localparam int A_PRIO_BASE = 16;
    localparam int A_VEC_BASE  = 32;
endpackage

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
    parameter int NN     = 7,
    parameter int PRIO_W = 3,
    localparam int IDX_W = (NN > 1) ? $clog2(NN) : 1
) (
    input  logic [NN-1:0]             pend_i,
    input  logic [NN-1:0][PRIO_W-1:0] prio_i,
    input  logic                      in_svc_i,
    input  logic [PRIO_W-1:0]         level_i,
    output logic                      elig_o,
    output logic [IDX_W-1:0]          idx_o
);
    logic              found;
    logic [PRIO_W-1:0] best_p;
    logic [IDX_W-1:0]  best_i;

    always_comb begin
        found  = 1'b0;
        best_p = '0;
        best_i = '0;
        for (int i = 0; i < NN; i++) begin
            if (pend_i[i] && (!found || prio_i[i] > best_p)) begin
                found  = 1'b1;
                best_p = prio_i[i];
                best_i = IDX_W'(i);
            end
        end
    end

    assign elig_o = found && (!in_svc_i || best_p > level_i);
    assign idx_o  = best_i;
endmodule

// File: rtl/vic_prio_stack.sv
module vic_prio_stack #(
    parameter int PRIO_W = 3,
    parameter int DEPTH  = 8,
    localparam int SP_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_ni,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [PRIO_W-1:0] push_val_i,
    output logic [PRIO_W-1:0] top_o,
    output logic              empty_o,
    output logic [CNT_W-1:0]  depth_o
);
    typedef struct packed {
        logic [DEPTH-1:0][PRIO_W-1:0] ent;
        logic [CNT_W-1:0]             cnt;
    } stk_t;

    stk_t             s_d, s_q;
    logic [CNT_W-1:0] n;

    always_comb begin
        s_d = s_q;
        n   = s_q.cnt;
        if (pop_i && n != '0) begin
            n = n - CNT_W'(1);
        end
        if (push_i && n < CNT_W'(DEPTH)) begin
            s_d.ent[n[SP_W-1:0]] = push_val_i;
            n = n + CNT_W'(1);
        end
        s_d.cnt = n;
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign top_o   = s_q.ent[SP_W'(s_q.cnt - CNT_W'(1))];
    assign empty_o = (s_q.cnt == '0);
    assign depth_o = s_q.cnt;
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
    import vic_pkg::*;
#(
    parameter int N_PERIPH = 4,
    parameter int PRIO_W   = 3,
    parameter int DATA_W   = 32
) (
    input  logic                    clk,
    input  logic                    rst_ni,
    input  logic [N_PERIPH+3:0]     src_i,
    input  logic                    bus_wr_i,
    input  logic                    bus_rd_i,
    input  logic [ADDR_W-1:0]       bus_addr_i,
    input  logic [DATA_W-1:0]       bus_wdata_i,
    output logic [DATA_W-1:0]       bus_rdata_o,
    output logic                    fiq_no,
    output logic                    irq_no
);
    localparam int NSRC  = N_PERIPH + 4;
    localparam int NN    = NSRC - 1;
    localparam int IDX_W = (NN > 1) ? $clog2(NN) : 1;
    localparam int DEPTH = 1 << PRIO_W;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [NSRC-1:0]              mask;
        logic [NN-1:0][PRIO_W-1:0]    prio;
        logic [NN-1:0][DATA_W-1:0]    vec;
        logic [DATA_W-1:0]            spur;
        logic [DATA_W-1:0]            fvec;
        logic [DATA_W-1:0]            rdata;
    } regs_t;

    regs_t              st_d, st_q;
    logic [NN-1:0]      pend;
    logic               arb_elig;
    logic [IDX_W-1:0]   arb_idx;
    logic               stk_push, stk_pop;
    logic [PRIO_W-1:0]  stk_top;
    logic               stk_empty;
    logic [CNT_W-1:0]   stk_cnt;

    for (genvar g = 0; g < NN; g++) begin : g_pend
        assign pend[g] = src_i[g+1] & st_q.mask[g+1];
    end

    vic_arbiter #(.NN(NN), .PRIO_W(PRIO_W)) u_arb (
        .pend_i   (pend),
        .prio_i   (st_q.prio),
        .in_svc_i (!stk_empty),
        .level_i  (stk_top),
        .elig_o   (arb_elig),
        .idx_o    (arb_idx)
    );

    vic_prio_stack #(.PRIO_W(PRIO_W), .DEPTH(DEPTH)) u_stk (
        .clk        (clk),
        .rst_ni     (rst_ni),
        .push_i     (stk_push),
        .pop_i      (stk_pop),
        .push_val_i (st_q.prio[arb_idx]),
        .top_o      (stk_top),
        .empty_o    (stk_empty),
        .depth_o    (stk_cnt)
    );

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        stk_push   = 1'b0;
        stk_pop    = 1'b0;

        if (bus_wr_i) begin
            case (bus_addr_i)
                ADDR_W'(A_EOI):  stk_pop = 1'b1;
                ADDR_W'(A_MSET): st_d.mask = st_q.mask | bus_wdata_i[NSRC-1:0];
                ADDR_W'(A_MCLR): st_d.mask = st_q.mask & ~bus_wdata_i[NSRC-1:0];
                ADDR_W'(A_SPUR): st_d.spur = bus_wdata_i;
                ADDR_W'(A_FVEC): st_d.fvec = bus_wdata_i;
                default: begin
                    for (int i = 0; i < NN; i++) begin
                        if (bus_addr_i == ADDR_W'(A_PRIO_BASE + i)) begin
                            st_d.prio[i] = bus_wdata_i[PRIO_W-1:0];
                        end
                        if (bus_addr_i == ADDR_W'(A_VEC_BASE + i)) begin
                            st_d.vec[i] = bus_wdata_i;
                        end
                    end
                end
            endcase
        end

        if (bus_rd_i) begin
            case (bus_addr_i)
                ADDR_W'(A_VEC): begin
                    st_d.rdata = arb_elig ? st_q.vec[arb_idx] : st_q.spur;
                    stk_push   = arb_elig;
                end
                ADDR_W'(A_MSET): st_d.rdata = DATA_W'(st_q.mask);
                ADDR_W'(A_SPUR): st_d.rdata = st_q.spur;
                ADDR_W'(A_FVEC): st_d.rdata = st_q.fvec;
                default: begin
                    for (int i = 0; i < NN; i++) begin
                        if (bus_addr_i == ADDR_W'(A_PRIO_BASE + i)) begin
                            st_d.rdata = DATA_W'(st_q.prio[i]);
                        end
                        if (bus_addr_i == ADDR_W'(A_VEC_BASE + i)) begin
                            st_d.rdata = st_q.vec[i];
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata_o = st_q.rdata;
    assign fiq_no      = ~(src_i[0] & st_q.mask[0]);
    assign irq_no      = ~arb_elig;
endmodule

// File: rtl/vic_checker.sv
module vic_checker
    import vic_pkg::*;
#(
    parameter int NSRC  = 8,
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic              clk,
    input logic              rst_ni,
    input logic [NSRC-1:0]   src_i,
    input logic              bus_wr_i,
    input logic              bus_rd_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic              wdata0,
    input logic              fiq_no,
    input logic              irq_no,
    input logic [CNT_W-1:0]  depth
);
    logic wr_only, rd_only;
    assign wr_only = bus_wr_i && !bus_rd_i;
    assign rd_only = bus_rd_i && !bus_wr_i;

    AST_FIQ_ON: assert property (@(posedge clk) disable iff (!rst_ni)
        (wr_only && bus_addr_i == ADDR_W'(A_MSET) && wdata0) |=> (fiq_no == !src_i[0])); // R2
    AST_FIQ_OFF: assert property (@(posedge clk) disable iff (!rst_ni)
        (wr_only && bus_addr_i == ADDR_W'(A_MCLR) && wdata0) |=> fiq_no); // R3
    AST_IRQ_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_ni)
        !irq_no |-> (|src_i[NSRC-1:1])); // R4
    AST_ACK_PUSH: assert property (@(posedge clk) disable iff (!rst_ni)
        (rd_only && bus_addr_i == ADDR_W'(A_VEC) && !irq_no) |=> (depth == $past(depth) + CNT_W'(1))); // R7
    AST_SPUR_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
        (rd_only && bus_addr_i == ADDR_W'(A_VEC) && irq_no) |=> $stable(depth)); // R6
    AST_EOI_POP: assert property (@(posedge clk) disable iff (!rst_ni)
        (wr_only && bus_addr_i == ADDR_W'(A_EOI) && depth != '0) |=> (depth == $past(depth) - CNT_W'(1))); // R8
    AST_EOI_EMPTY: assert property (@(posedge clk) disable iff (!rst_ni)
        (wr_only && bus_addr_i == ADDR_W'(A_EOI) && depth == '0) |=> (depth == '0)); // R8
    AST_DEPTH_MAX: assert property (@(posedge clk) disable iff (!rst_ni)
        depth <= CNT_W'(DEPTH)); // R7
endmodule

bind vic_ctrl vic_checker #(.NSRC(N_PERIPH + 4), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .src_i      (src_i),
    .bus_wr_i   (bus_wr_i),
    .bus_rd_i   (bus_rd_i),
    .bus_addr_i (bus_addr_i),
    .wdata0     (bus_wdata_i[0]),
    .fiq_no     (fiq_no),
    .irq_no     (irq_no),
    .depth      (stk_cnt)
);

// File: tb/vic_ctrl_tb.sv
module vic_ctrl_tb;
    import vic_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam int N_PERIPH   = 4;
    localparam int NSRC       = N_PERIPH + 4;
    localparam int NN         = NSRC - 1;

    logic              clk = 1'b0;
    logic              rst_ni = 1'b0;
    logic [NSRC-1:0]   src = '0;
    logic              wr = 1'b0, rd = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              fiq_no, irq_no;

    vic_ctrl #(.N_PERIPH(N_PERIPH), .PRIO_W(3), .DATA_W(32)) u_dut (
        .clk(clk), .rst_ni(rst_ni), .src_i(src), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .fiq_no(fiq_no), .irq_no(irq_no)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_err = 0;
    string cur_req = "R1";

    // behavioural reference
    logic [NSRC-1:0] m_mask = '0;
    int              m_prio [NN];
    logic [31:0]     m_vec  [NN];
    logic [31:0]     m_spur = '0, m_fvec = '0, m_rd = '0;
    int              m_stk [$];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int pick(input logic [NSRC-1:0] s);
        int best = -1;
        for (int i = 0; i < NN; i++)
            if (s[i+1] && m_mask[i+1] && (best < 0 || m_prio[i] > m_prio[best])) best = i;
        if (best >= 0 && m_stk.size() > 0 && m_prio[best] <= m_stk[$]) best = -1;
        return best;
    endfunction

    task automatic tick(input logic w, input logic r, input int a, input logic [31:0] d,
                        input logic [NSRC-1:0] s);
        int sel;
        logic [31:0] nrd;
        @(negedge clk);
        wr = w; rd = r; addr = ADDR_W'(a); wdata = d; src = s;
        #1;
        sel = pick(s);
        chk("R2", {31'd0, fiq_no}, {31'd0, !(s[0] && m_mask[0])});
        chk("R4", {31'd0, irq_no}, {31'd0, sel < 0});
        chk(cur_req, rdata, m_rd);
        nrd = '0;
        if (r) begin
            if (a == A_VEC) begin
                if (sel >= 0) begin nrd = m_vec[sel]; m_stk.push_back(m_prio[sel]); end
                else nrd = m_spur;
            end else if (a == A_MSET) nrd = 32'(m_mask);
            else if (a == A_SPUR) nrd = m_spur;
            else if (a == A_FVEC) nrd = m_fvec;
            else if (a >= A_PRIO_BASE && a < A_PRIO_BASE + NN) nrd = 32'(m_prio[a - A_PRIO_BASE]);
            else if (a >= A_VEC_BASE && a < A_VEC_BASE + NN) nrd = m_vec[a - A_VEC_BASE];
        end
        if (w) begin
            if (a == A_EOI) begin if (m_stk.size() > 0) void'(m_stk.pop_back()); end
            else if (a == A_MSET) m_mask = m_mask | d[NSRC-1:0];
            else if (a == A_MCLR) m_mask = m_mask & ~d[NSRC-1:0];
            else if (a == A_SPUR) m_spur = d;
            else if (a == A_FVEC) m_fvec = d;
            else if (a >= A_PRIO_BASE && a < A_PRIO_BASE + NN) m_prio[a - A_PRIO_BASE] = int'(d[2:0]);
            else if (a >= A_VEC_BASE && a < A_VEC_BASE + NN) m_vec[a - A_VEC_BASE] = d;
        end
        m_rd = nrd;
    endtask

    task automatic rdreg(input int a, input logic [NSRC-1:0] s); tick(0, 1, a, 0, s); endtask
    task automatic wrreg(input int a, input logic [31:0] d, input logic [NSRC-1:0] s); tick(1, 0, a, d, s); endtask
    task automatic idle(input logic [NSRC-1:0] s); tick(0, 0, 0, 0, s); endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < NN; i++) begin m_prio[i] = 0; m_vec[i] = '0; end
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        // R1: reset state seen at the ports
        cur_req = "R1";
        idle('0);
        rdreg(A_MSET, '0); rdreg(A_SPUR, '0); rdreg(A_PRIO_BASE + 2, '0); idle('0);
        // R9: configuration round trip
        cur_req = "R9";
        begin
            int pr [NN] = '{2, 4, 1, 5, 5, 7, 0};
            for (int i = 0; i < NN; i++) begin
                wrreg(A_PRIO_BASE + i, 32'(pr[i]) | 32'hF0, '0);
                wrreg(A_VEC_BASE + i, 32'h1000 + 32'(i * 16), '0);
            end
        end
        wrreg(A_SPUR, 32'hDEAD_0000, '0); wrreg(A_FVEC, 32'hFA57_0000, '0);
        for (int i = 0; i < NN; i++) begin rdreg(A_PRIO_BASE + i, '0); rdreg(A_VEC_BASE + i, '0); end
        rdreg(A_SPUR, '0); rdreg(A_FVEC, '0); rdreg(12, '0); idle('0);
        // R3: set/clear enables, zero bits leave them alone
        cur_req = "R3";
        wrreg(A_MSET, 32'h0000_00A5, '0); rdreg(A_MSET, '0);
        wrreg(A_MCLR, 32'h0, '0); wrreg(A_MSET, 32'h0, '0); rdreg(A_MSET, '0);
        wrreg(A_MCLR, 32'h0000_0081, 8'h01); rdreg(A_MSET, 8'h01);
        wrreg(A_MSET, 32'hFF, 8'h01); rdreg(A_MSET, 8'h01); idle('0);
        // R2: fast line alone, and with the normal path busy
        cur_req = "R2";
        idle(8'h01); idle(8'h41); wrreg(A_MCLR, 32'h1, 8'h01); idle(8'h01); wrreg(A_MSET, 32'h1, 8'h00); idle('0);
        // R5: priority pick with a tie (src4, src5 at level 5)
        cur_req = "R5";
        idle(8'h32); rdreg(A_VEC, 8'h32); idle(8'h32);
        // R7: nesting, only strictly higher preempts
        cur_req = "R7";
        idle(8'h32); rdreg(A_VEC, 8'h32); idle(8'h72); rdreg(A_VEC, 8'h72); idle(8'h72);
        rdreg(A_VEC, 8'h72); idle(8'h72);
        // R8: EOI pops back down, then on empty does nothing
        cur_req = "R8";
        wrreg(A_EOI, 0, 8'h72); idle(8'h72); wrreg(A_EOI, 0, 8'h72); idle(8'h72);
        wrreg(A_EOI, 0, 8'h02); wrreg(A_EOI, 0, 8'h02); wrreg(A_EOI, 0, 8'h00); idle(8'h02);
        // R6: spurious with nothing pending, and with only a lower level pending
        cur_req = "R6";
        rdreg(A_VEC, 8'h00); idle(8'h00);
        rdreg(A_VEC, 8'h10); rdreg(A_VEC, 8'h02); idle(8'h02);
        wrreg(A_EOI, 0, 8'h00); idle('0);
        // R5: read collides with a higher source rising / the only source falling
        cur_req = "R5";
        idle(8'h02); rdreg(A_VEC, 8'h42); idle(8'h42); wrreg(A_EOI, 0, 8'h00);
        idle(8'h04); rdreg(A_VEC, 8'h00); idle('0);
        // mixed random traffic
        cur_req = "R4";
        begin
            logic [NSRC-1:0] s = '0;
            for (int k = 0; k < 1500; k++) begin
                int op = int'($urandom_range(0, 11));
                if ($urandom_range(0, 2) == 0) s = NSRC'($urandom);
                if (k == 700) begin
                    cur_req = "R7";
                    for (int i = 0; i < NN; i++) wrreg(A_PRIO_BASE + i, 32'(i), s);
                end
                case (op)
                    0, 1, 2: rdreg(A_VEC, s);
                    3, 4:    wrreg(A_EOI, 0, s);
                    5:       wrreg(A_MSET, $urandom, s);
                    6:       wrreg(A_MCLR, $urandom & 32'h3F, s);
                    7:       rdreg(A_MSET, s);
                    8:       wrreg(A_PRIO_BASE + int'($urandom_range(0, NN - 1)), $urandom, s);
                    default: idle(s);
                endcase
            end
        end
        idle('0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule